// File: doc/BRIEF.md
# UART Multiprocessor Address Recognition Filter

This block sits behind a UART receiver and decides, for every completed frame, whether the receive-interrupt flag should be raised. The receiver hands it the received byte, the ninth data bit, the sampled stop bit and a one-cycle frame-done strobe. When multiprocessor filtering is enabled, only address frames that match the local slave address are passed. An address frame is one whose ninth bit is 1 in the 9-bit modes, or whose stop bit is 1 in the 8-bit mode. A frame can match in one of two ways:

- **Individual/group compare.** A per-bit mask selects which slave-address bits take part in the compare. One mask value can therefore address a slave individually or address a group of slaves.
- **Broadcast compare.** A broadcast pattern is derived from the same slave-address and mask values.

The block also keeps a sticky framing-error flag. That flag shares one control bit position with the most significant bit of the serial mode. A view selector decides which of the two a read or write of that bit position reaches.

Top module: `mpc_addr_filter`

## Requirements
- R1: After reset, `rx_flag_set` is 0. `fe_flag` is 0. The stored mode MSB is 0, so `mode_o` reads as `{0, mode_lsb}` and `top_rdata` reads 0.
- R2: `rx_flag_set` is a single-cycle pulse. It is high only in the cycle after a cycle in which `frame_done` was high.
- R3: With `mp_en` = 0, every completed frame produces the pulse, in every mode, whatever the ninth and stop bits are. In mode 0 (`mode_o` = 0) the pulse is produced even when `mp_en` = 1.
- R4: The individual address is `slave_addr & addr_mask`. A byte matches it when it equals `slave_addr` on every bit where `addr_mask` is 1. Bits where the mask is 0 are ignored.
- R5: The broadcast pattern is `slave_addr | addr_mask`. A byte matches it when it has a 1 in every position where that pattern is 1. A broadcast match is accepted just like an individual match.
- R6: In modes 2 and 3 (`mode_o` = 2 or 3) with `mp_en` = 1, a frame with ninth bit 0 never produces the pulse. A frame with ninth bit 1 produces it only on an R4 or R5 match.
- R7: In mode 1 with `mp_en` = 1, the pulse is produced only when the stop bit is 1 and the byte matches. The ninth-bit input has no effect in this case.
- R8: In modes 1 to 3, a frame whose stop bit samples 0 sets `fe_flag` at the same edge that registers the frame. Later good frames leave it set. A mode 0 frame never sets it.
- R9: A write (`top_wr`) with `fe_view` = 1 loads `top_wdata` into `fe_flag` and leaves the mode MSB unchanged. This is the only way `fe_flag` is cleared.
- R10: A write with `fe_view` = 0 loads `top_wdata` into the mode MSB (`mode_o[1]`) and leaves `fe_flag` unchanged. `top_rdata` shows `fe_flag` when `fe_view` = 1 and the mode MSB when `fe_view` = 0.
- R11: When a framing error and a software clear of `fe_flag` land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: the frame fields are valid |
| rx_data | input | 8 | Received data byte |
| rx_bit9 | input | 1 | Received ninth bit (9-bit modes) |
| rx_stop | input | 1 | Sampled stop bit |
| mode_lsb | input | 1 | Serial mode LSB |
| mp_en | input | 1 | Multiprocessor filtering enable |
| slave_addr | input | 8 | Local slave address |
| addr_mask | input | 8 | Per-bit compare mask |
| fe_view | input | 1 | Selects framing error (1) or mode MSB (0) at the shared bit |
| top_wr | input | 1 | Write strobe for the shared bit |
| top_wdata | input | 1 | Value written to the shared bit |
| rx_flag_set | output | 1 | Pulse: set the receive-interrupt flag |
| fe_flag | output | 1 | Sticky framing-error flag |
| top_rdata | output | 1 | Read view of the shared bit |
| mode_o | output | 2 | Current serial mode `{msb, lsb}` |

## Verification
The hardest state to reach from the ports is a framing error that coincides with a software clear of the flag. To reach it, the bench first leaves the flag set. It then issues the clear write and a frame with stop bit 0 in the same cycle, and checks that the flag stays set. A second corner is telling the two match paths apart. For this the bench picks slave-address and mask pairs where one byte passes only the broadcast pattern and another passes only the individual compare. A third is the mode MSB, which can only be reached through the shared bit. The bench therefore switches mode by writing with the view selector at 0 and reads the result back through the mode output.

// File: rtl/mpc_pkg.sv
// Shared types for the multiprocessor address filter.
package mpc_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT = 2'd0,
        MODE_8BIT  = 2'd1,
        MODE_9FIX  = 2'd2,
        MODE_9VAR  = 2'd3
    } uart_mode_e;
endpackage

// File: rtl/mpc_addr_match.sv
// Address comparator: per-bit individual compare under mask plus broadcast
// compare. Purely combinational. Assumes inputs are stable in the cycle used.
module mpc_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] own_addr,
    input  logic [W-1:0] care_mask,
    output logic         hit_given,
    output logic         hit_bcast
);
    logic [W-1:0] given_ok;
    logic [W-1:0] bcast_ok;
    logic [W-1:0] bcast_pat;

    assign bcast_pat = own_addr | care_mask;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Individual compare: a masked-off bit always passes.
        assign given_ok[b] = !care_mask[b] || (rx_byte[b] == own_addr[b]);
        // Broadcast compare: a 1 in the pattern demands a 1 in the byte.
        assign bcast_ok[b] = !bcast_pat[b] || rx_byte[b];
    end

    assign hit_given = &given_ok;
    assign hit_bcast = &bcast_ok;
endmodule

// File: rtl/mpc_accept_gate.sv
// Accept decision for a completed frame, from mode, filter enable and the
// address-match result. Combinational; used only on the frame-done cycle.
module mpc_accept_gate
    import mpc_pkg::*;
(
    input  uart_mode_e mode,
    input  logic       mp_en,
    input  logic       bit9,
    input  logic       stop_bit,
    input  logic       addr_hit,
    output logic       accept
);
    // Purpose: choose the qualifier that marks an address frame in this mode.
    always_comb begin
        accept = 1'b1;
        if (mp_en) begin
            unique case (mode)
                MODE_SHIFT: accept = 1'b1;
                MODE_8BIT:  accept = stop_bit && addr_hit;
                MODE_9FIX,
                MODE_9VAR:  accept = bit9 && addr_hit;
                default:    accept = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/mpc_ctl_alias.sv
// Shared control bit: holds the mode MSB and the sticky framing-error flag,
// which share one bit position selected by a view bit. A hardware set of the
// error flag wins over a same-cycle software write.
module mpc_ctl_alias (
    input  logic clk,
    input  logic rst_n,
    input  logic fe_set,
    input  logic fe_view,
    input  logic top_wr,
    input  logic top_wdata,
    output logic fe_flag,
    output logic mode_msb,
    output logic top_rdata
);
    // Purpose: update the framing-error flag from hardware or software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fe_flag <= 1'b0;
        else if (fe_set)
            fe_flag <= 1'b1;
        else if (top_wr && fe_view)
            fe_flag <= top_wdata;
    end

    // Purpose: update the mode MSB from software writes in mode view.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_msb <= 1'b0;
        else if (top_wr && !fe_view)
            mode_msb <= top_wdata;
    end

    assign top_rdata = fe_view ? fe_flag : mode_msb;
endmodule

// File: rtl/mpc_addr_filter.sv
// Top: decides per completed frame whether to pulse the receive flag, with
// hardware address filtering in multiprocessor mode, and captures framing
// errors. Assumes frame_done is a single-cycle strobe with fields valid.
module mpc_addr_filter
    import mpc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_bit9,
    input  logic              rx_stop,
    input  logic              mode_lsb,
    input  logic              mp_en,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              fe_view,
    input  logic              top_wr,
    input  logic              top_wdata,
    output logic              rx_flag_set,
    output logic              fe_flag,
    output logic              top_rdata,
    output logic [1:0]        mode_o
);
    logic       hit_given;
    logic       hit_bcast;
    logic       accept;
    logic       mode_msb;
    logic       fe_set;
    uart_mode_e cur_mode;

    assign cur_mode = uart_mode_e'({mode_msb, mode_lsb});
    assign mode_o   = {mode_msb, mode_lsb};
    assign fe_set   = frame_done && (cur_mode != MODE_SHIFT) && !rx_stop;

    mpc_addr_match #(.W(DATA_W)) u_match (
        .rx_byte   (rx_data),
        .own_addr  (slave_addr),
        .care_mask (addr_mask),
        .hit_given (hit_given),
        .hit_bcast (hit_bcast)
    );

    mpc_accept_gate u_gate (
        .mode     (cur_mode),
        .mp_en    (mp_en),
        .bit9     (rx_bit9),
        .stop_bit (rx_stop),
        .addr_hit (hit_given || hit_bcast),
        .accept   (accept)
    );

    mpc_ctl_alias u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fe_set    (fe_set),
        .fe_view   (fe_view),
        .top_wr    (top_wr),
        .top_wdata (top_wdata),
        .fe_flag   (fe_flag),
        .mode_msb  (mode_msb),
        .top_rdata (top_rdata)
    );

    // Purpose: register the one-cycle receive-flag set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_flag_set <= 1'b0;
        else
            rx_flag_set <= frame_done && accept;
    end
endmodule

// File: rtl/mpc_addr_filter_chk.sv
// Assertion checker for mpc_addr_filter, attached with bind.
module mpc_addr_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_done,
    input logic       rx_bit9,
    input logic       rx_stop,
    input logic       mp_en,
    input logic       fe_view,
    input logic       top_wr,
    input logic       top_wdata,
    input logic       rx_flag_set,
    input logic       fe_flag,
    input logic [1:0] mode_o
);
    // R2
    pulse_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag_set |-> $past(frame_done));

    // R3
    open_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !mp_en) |=> rx_flag_set);

    // R6
    data_frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && mp_en && mode_o[1] && !rx_bit9) |=> !rx_flag_set);

    // R7
    bad_stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && mp_en && mode_o == 2'd1 && !rx_stop) |=> !rx_flag_set);

    // R8
    fe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && mode_o != 2'd0 && !rx_stop) |=> fe_flag);

    // R9
    fe_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fe_flag) |-> $past(top_wr && fe_view && !top_wdata));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(top_wr && !fe_view) |=> $stable(mode_o[1]));
endmodule

bind mpc_addr_filter mpc_addr_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_done  (frame_done),
    .rx_bit9     (rx_bit9),
    .rx_stop     (rx_stop),
    .mp_en       (mp_en),
    .fe_view     (fe_view),
    .top_wr      (top_wr),
    .top_wdata   (top_wdata),
    .rx_flag_set (rx_flag_set),
    .fe_flag     (fe_flag),
    .mode_o      (mode_o)
);

// File: tb/tb_mpc_addr_filter.sv
// Directed bench for mpc_addr_filter: one task per scenario.
module tb_mpc_addr_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_done = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_bit9 = 1'b0;
    logic       rx_stop = 1'b1;
    logic       mode_lsb = 1'b0;
    logic       mp_en = 1'b0;
    logic [7:0] slave_addr = '0;
    logic [7:0] addr_mask = '0;
    logic       fe_view = 1'b0;
    logic       top_wr = 1'b0;
    logic       top_wdata = 1'b0;
    logic       rx_flag_set;
    logic       fe_flag;
    logic       top_rdata;
    logic [1:0] mode_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mpc_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_stop(rx_stop), .mode_lsb(mode_lsb), .mp_en(mp_en),
        .slave_addr(slave_addr), .addr_mask(addr_mask), .fe_view(fe_view),
        .top_wr(top_wr), .top_wdata(top_wdata), .rx_flag_set(rx_flag_set),
        .fe_flag(fe_flag), .top_rdata(top_rdata), .mode_o(mode_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Send one frame; returns the flag pulse seen in the following cycle.
    task automatic send(input logic [7:0] d, input logic b9, input logic st,
                        output logic got);
        @(negedge clk);
        rx_data = d; rx_bit9 = b9; rx_stop = st; frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        got = rx_flag_set;
        @(negedge clk);
        chk("R2 pulse width", {7'd0, rx_flag_set}, 8'd0);
        rx_stop = 1'b1;
    endtask

    task automatic wr_top(input logic sel, input logic v);
        @(negedge clk);
        fe_view = sel; top_wr = 1'b1; top_wdata = v;
        @(negedge clk);
        top_wr = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_lsb = m[0];
        wr_top(1'b0, m[1]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 flag", {7'd0, rx_flag_set}, 8'd0);
        chk("R1 fe", {7'd0, fe_flag}, 8'd0);
        chk("R1 mode", {6'd0, mode_o}, 8'd0);
        chk("R1 rdata", {7'd0, top_rdata}, 8'd0);
    endtask

    task automatic t_open();
        logic got;
        mp_en = 1'b0;
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1:0]);
            send(8'h5A, 1'b0, 1'b1, got);
            chk("R3 open accept", {7'd0, got}, 8'd1);
        end
        mp_en = 1'b1;
        set_mode(2'd0);
        send(8'h00, 1'b0, 1'b1, got);
        chk("R3 mode0 ignores mp_en", {7'd0, got}, 8'd1);
    endtask

    task automatic t_nine_bit();
        logic got;
        mp_en = 1'b1; slave_addr = 8'hA5; addr_mask = 8'hF0;
        set_mode(2'd3);
        chk("R10 mode readback", {6'd0, mode_o}, 8'd3);
        send(8'hA3, 1'b1, 1'b1, got);
        chk("R4 given match", {7'd0, got}, 8'd1);
        send(8'hB5, 1'b1, 1'b1, got);
        chk("R4 given miss", {7'd0, got}, 8'd0);
        send(8'hF5, 1'b1, 1'b1, got);
        chk("R5 broadcast match", {7'd0, got}, 8'd1);
        send(8'hF4, 1'b1, 1'b1, got);
        chk("R5 broadcast miss", {7'd0, got}, 8'd0);
        send(8'hA3, 1'b0, 1'b1, got);
        chk("R6 data frame dropped", {7'd0, got}, 8'd0);
        set_mode(2'd2);
        slave_addr = 8'h3C; addr_mask = 8'hFF;
        send(8'h3C, 1'b1, 1'b1, got);
        chk("R4 exact match", {7'd0, got}, 8'd1);
        send(8'h3D, 1'b1, 1'b1, got);
        chk("R4 exact miss", {7'd0, got}, 8'd0);
        send(8'hFF, 1'b1, 1'b1, got);
        chk("R5 all-ones broadcast", {7'd0, got}, 8'd1);
        slave_addr = 8'h12; addr_mask = 8'h00;
        send(8'h77, 1'b1, 1'b1, got);
        chk("R4 empty mask accepts", {7'd0, got}, 8'd1);
    endtask

    task automatic t_mode1();
        logic got;
        mp_en = 1'b1; slave_addr = 8'h3C; addr_mask = 8'hFF;
        set_mode(2'd1);
        send(8'h3C, 1'b0, 1'b1, got);
        chk("R7 match good stop", {7'd0, got}, 8'd1);
        send(8'h3C, 1'b1, 1'b0, got);
        chk("R7 bad stop dropped", {7'd0, got}, 8'd0);
        send(8'h3D, 1'b1, 1'b1, got);
        chk("R7 miss", {7'd0, got}, 8'd0);
    endtask

    task automatic t_fe();
        logic got;
        wr_top(1'b1, 1'b0);
        chk("R9 fe cleared", {7'd0, fe_flag}, 8'd0);
        mp_en = 1'b0;
        set_mode(2'd0);
        send(8'h00, 1'b0, 1'b0, got);
        chk("R8 mode0 no fe", {7'd0, fe_flag}, 8'd0);
        set_mode(2'd3);
        send(8'h00, 1'b0, 1'b0, got);
        chk("R8 fe set", {7'd0, fe_flag}, 8'd1);
        send(8'h00, 1'b0, 1'b1, got);
        chk("R8 fe sticky", {7'd0, fe_flag}, 8'd1);
        fe_view = 1'b1; #1;
        chk("R10 rdata fe view", {7'd0, top_rdata}, 8'd1);
        wr_top(1'b0, 1'b0);
        chk("R10 mode write keeps fe", {7'd0, fe_flag}, 8'd1);
        chk("R10 mode msb written", {6'd0, mode_o}, 8'd1);
        fe_view = 1'b0; #1;
        chk("R10 rdata mode view", {7'd0, top_rdata}, 8'd0);
        // R11: clear and framing error in the same cycle (mode 1 now).
        @(negedge clk);
        fe_view = 1'b1; top_wr = 1'b1; top_wdata = 1'b0;
        rx_data = 8'h00; rx_stop = 1'b0; frame_done = 1'b1;
        @(negedge clk);
        top_wr = 1'b0; frame_done = 1'b0; rx_stop = 1'b1;
        chk("R11 set wins", {7'd0, fe_flag}, 8'd1);
        wr_top(1'b1, 1'b0);
        chk("R9 clear by write", {7'd0, fe_flag}, 8'd0);
        chk("R9 mode untouched", {6'd0, mode_o}, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_open();
        t_nine_bit();
        t_mode1();
        t_fe();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule